// File: doc/BRIEF.md
# Self-Timed Synchronous SRAM Access Controller

This block is a 64-word by 4-bit embedded memory with a small sequencer that keeps the array active only as long as an access needs. When the controller is idle and chip enable is high at a clock edge, the address, write data, write enable and output enable are captured in an input register. A timed sequence then starts. The decoders and the word line turn on, and a one-bit marker is launched into a dummy reference path. When the marker comes out of that path, the word line and decoder enables turn off. A read then fires a one-cycle sense strobe. Every access ends with one cycle of bit-line precharge before the controller returns to idle.

The dummy path stands in for a reference cell with a fixed stored value. Its delay is a whole number of fast-clock cycles, set by `DUMMY_CYC`. The storage is a behavioural register array. The read output bus changes only when a read's sense strobe completes; at all other times it holds its value. A separate drive flag tells the surrounding logic whether the bus should be driven or left in high impedance.

Top module: `sram_seq_top`

## Requirements
- R1: When `busy_o` is low and `ce_i` is high at a rising clock edge, an access starts: from the next cycle `busy_o`, `wl_o` and `dec_en_o` are high.
- R2: `wl_o` and `dec_en_o` stay high for exactly `DUMMY_CYC` consecutive cycles per access (default 3), then fall together.
- R3: On a read (`we_i` low at the start edge), `sense_o` is high for exactly one cycle, immediately after the word line falls. At the end of that cycle `rdata_o` takes the word at the captured address, and `rdata_drv_o` takes the captured `oe_i`.
- R4: `prech_o` is high for exactly one cycle. On a read it follows the sense cycle; on a write it directly follows the word-line cycles. After it, `busy_o` is low. At most one of `wl_o`, `sense_o` and `prech_o` is high in any cycle.
- R5: On a write (`we_i` high at the start edge), the captured data is stored at the captured address by the end of the word-line phase. No sense strobe occurs, and `rdata_o` and `rdata_drv_o` are unchanged.
- R6: `rdata_o` and `rdata_drv_o` keep their previous values in every cycle that does not end a sense strobe.
- R7: While idle with `ce_i` low, no activity occurs: `busy_o`, `wl_o`, `sense_o` and `prech_o` stay low, and the stored words are unchanged whatever `we_i`, `addr_i` and `wdata_i` do.
- R8: Changes on `ce_i`, `we_i`, `oe_i`, `addr_i` and `wdata_i` while `busy_o` is high neither start a new access nor alter the one in progress.
- R9: After reset, the controller is idle, all strobes are low, `rdata_o` is 0 and `rdata_drv_o` is 0.
- R10: A read with `oe_i` low at its start edge still updates `rdata_o`, but leaves `rdata_drv_o` low (output in high impedance).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; also times the dummy path |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ce_i | input | 1 | Chip enable; starts an access when idle |
| we_i | input | 1 | 1 = write, 0 = read |
| oe_i | input | 1 | Output enable captured for reads |
| addr_i | input | 6 | Word address |
| wdata_i | input | 4 | Write data |
| rdata_o | output | 4 | Read data, held between reads |
| rdata_drv_o | output | 1 | 1 = drive `rdata_o`, 0 = high impedance |
| wl_o | output | 1 | Word-line enable |
| dec_en_o | output | 1 | Pre-, row and column decoder enable |
| sense_o | output | 1 | Sense-amplifier strobe |
| prech_o | output | 1 | Bit-line precharge / equalize |
| busy_o | output | 1 | Access sequence in progress |

## Verification
The start edge is counted as cycle 0. The word line and decoders are then high in cycles 1 to `DUMMY_CYC`. A read senses in cycle `DUMMY_CYC`+1 and precharges in the cycle after. A write precharges in cycle `DUMMY_CYC`+1. The new read word appears from cycle `DUMMY_CYC`+2. The bench samples each of these cycles on the falling clock edge and compares them with a per-cycle expected pattern. It checks that `rdata_o` keeps its old value through the word-line cycles. It checks the returned data and drive flag only once the sequence has gone idle again. It drives junk on the inputs during the word-line cycles, and holds chip enable low from the sense cycle onward so that the following idle edge cannot start an unintended access.

// File: rtl/sram_seq_pkg.sv
`timescale 1ns/1ps
package sram_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ACCESS = 2'd1,
    ST_SENSE  = 2'd2,
    ST_PRECH  = 2'd3
  } seq_state_e;
endpackage

// File: rtl/sram_in_latch.sv
`timescale 1ns/1ps
module sram_in_latch #(
  parameter int AW = 6,
  parameter int DW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  input  logic          wr_i,
  input  logic          oe_i,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] data_o,
  output logic          wr_o,
  output logic          oe_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o <= '0;
      data_o <= '0;
      wr_o   <= 1'b0;
      oe_o   <= 1'b0;
    end else if (load_i) begin
      addr_o <= addr_i;
      data_o <= data_i;
      wr_o   <= wr_i;
      oe_o   <= oe_i;
    end
  end
endmodule

// File: rtl/sram_dummy_path.sv
`timescale 1ns/1ps
// Reference path: a marker bit travels DUMMY_CYC stages, emulating the replica access.
module sram_dummy_path #(
  parameter int DUMMY_CYC = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic launch_i,
  output logic done_o
);
  logic [DUMMY_CYC-1:0] dly_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) dly_q <= '0;
    else         dly_q <= (dly_q << 1) | DUMMY_CYC'(launch_i);
  end

  assign done_o = dly_q[DUMMY_CYC-1];
endmodule

// File: rtl/sram_seq_fsm.sv
`timescale 1ns/1ps
module sram_seq_fsm
  import sram_seq_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic wr_i,
  input  logic done_i,
  output logic launch_o,
  output logic wl_o,
  output logic dec_en_o,
  output logic sense_o,
  output logic prech_o,
  output logic busy_o,
  output logic commit_o
);
  seq_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (req_i)  state_d = ST_ACCESS;
      ST_ACCESS: if (done_i) state_d = wr_i ? ST_PRECH : ST_SENSE;
      ST_SENSE:  state_d = ST_PRECH;
      ST_PRECH:  state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign launch_o = (state_q == ST_IDLE) && req_i;
  assign wl_o     = (state_q == ST_ACCESS);
  assign dec_en_o = (state_q == ST_ACCESS);
  assign sense_o  = (state_q == ST_SENSE);
  assign prech_o  = (state_q == ST_PRECH);
  assign busy_o   = (state_q != ST_IDLE);
  assign commit_o = (state_q == ST_ACCESS) && done_i && wr_i;
endmodule

// File: rtl/sram_array.sv
`timescale 1ns/1ps
module sram_array #(
  parameter int AW = 6,
  parameter int DW = 4
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[addr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[addr_i];
endmodule

// File: rtl/sram_seq_top.sv
`timescale 1ns/1ps
module sram_seq_top #(
  parameter int AW        = 6,
  parameter int DW        = 4,
  parameter int DUMMY_CYC = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ce_i,
  input  logic          we_i,
  input  logic          oe_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          rdata_drv_o,
  output logic          wl_o,
  output logic          dec_en_o,
  output logic          sense_o,
  output logic          prech_o,
  output logic          busy_o
);
  logic          launch, done, commit;
  logic [AW-1:0] lat_addr;
  logic [DW-1:0] lat_data, arr_rdata;
  logic          lat_wr, lat_oe;

  sram_in_latch #(.AW(AW), .DW(DW)) u_latch (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (launch),
    .addr_i (addr_i),
    .data_i (wdata_i),
    .wr_i   (we_i),
    .oe_i   (oe_i),
    .addr_o (lat_addr),
    .data_o (lat_data),
    .wr_o   (lat_wr),
    .oe_o   (lat_oe)
  );

  sram_dummy_path #(.DUMMY_CYC(DUMMY_CYC)) u_dummy (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .launch_i (launch),
    .done_o   (done)
  );

  sram_seq_fsm u_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (ce_i),
    .wr_i     (lat_wr),
    .done_i   (done),
    .launch_o (launch),
    .wl_o     (wl_o),
    .dec_en_o (dec_en_o),
    .sense_o  (sense_o),
    .prech_o  (prech_o),
    .busy_o   (busy_o),
    .commit_o (commit)
  );

  sram_array #(.AW(AW), .DW(DW)) u_array (
    .clk_i   (clk_i),
    .we_i    (commit),
    .addr_i  (lat_addr),
    .wdata_i (lat_data),
    .rdata_o (arr_rdata)
  );

  // Output stage: updated only at the end of a sense strobe, held otherwise.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o     <= '0;
      rdata_drv_o <= 1'b0;
    end else if (sense_o) begin
      rdata_o     <= arr_rdata;
      rdata_drv_o <= lat_oe;
    end
  end
endmodule

// File: rtl/sram_seq_chk.sv
`timescale 1ns/1ps
module sram_seq_chk #(
  parameter int DW        = 4,
  parameter int DUMMY_CYC = 3
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          ce_i,
  input logic          busy_o,
  input logic          wl_o,
  input logic          dec_en_o,
  input logic          sense_o,
  input logic          prech_o,
  input logic [DW-1:0] rdata_o,
  input logic          rdata_drv_o
);
  localparam int CW = $clog2(DUMMY_CYC + 2);
  logic [CW-1:0] wl_len_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   wl_len_q <= '0;
    else if (wl_o) wl_len_q <= wl_len_q + 1'b1;
    else           wl_len_q <= '0;
  end

  a_r1_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && ce_i) |=> (busy_o && wl_o && dec_en_o));

  a_r2_wl_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(wl_o) |-> (wl_len_q == CW'(DUMMY_CYC)));

  a_r2_wl_cap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wl_o |-> (wl_len_q < CW'(DUMMY_CYC)));

  a_r3_sense_after_wl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sense_o |-> ($past(wl_o) && !wl_o));

  a_r4_prech_after_sense: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sense_o |=> (prech_o && !sense_o));

  a_r4_prech_then_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prech_o |=> !busy_o);

  a_r4_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({wl_o, sense_o, prech_o}));

  a_r6_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(sense_o) |-> ($stable(rdata_o) && $stable(rdata_drv_o)));

  a_r7_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !ce_i) |=> !busy_o);
endmodule

bind sram_seq_top sram_seq_chk #(.DW(DW), .DUMMY_CYC(DUMMY_CYC)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ce_i        (ce_i),
  .busy_o      (busy_o),
  .wl_o        (wl_o),
  .dec_en_o    (dec_en_o),
  .sense_o     (sense_o),
  .prech_o     (prech_o),
  .rdata_o     (rdata_o),
  .rdata_drv_o (rdata_drv_o)
);

// File: tb/sim_sram_seq_top.sv
`timescale 1ns/1ps
module sim_sram_seq_top;
  localparam int D = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ce = 1'b0, we = 1'b0, oe = 1'b0;
  logic [5:0] addr = '0;
  logic [3:0] wd = '0;
  logic [3:0] rdata;
  logic       drv, wl, dec_en, sense, prech, busy;

  int  n_chk = 0, n_fail = 0;
  bit  done = 1'b0;
  logic [3:0] exp_mem [64];
  logic [3:0] exp_rdata = '0;
  logic       exp_drv = 1'b0;

  always #5 clk = ~clk;

  sram_seq_top u0 (
    .clk_i(clk), .rst_ni(rst_n), .ce_i(ce), .we_i(we), .oe_i(oe),
    .addr_i(addr), .wdata_i(wd), .rdata_o(rdata), .rdata_drv_o(drv),
    .wl_o(wl), .dec_en_o(dec_en), .sense_o(sense), .prech_o(prech), .busy_o(busy)
  );

  task automatic check(bit ok, string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // Expected {busy, wl, sense, prech} in cycle k after the start edge.
  function automatic logic [3:0] exp_seq(int k, bit rd);
    if (k <= D) return 4'b1100;
    if (rd) begin
      if (k == D + 1) return 4'b1010;
      if (k == D + 2) return 4'b1001;
    end else if (k == D + 1) return 4'b1001;
    return 4'b0000;
  endfunction

  task automatic access(bit wr, bit oe_v, logic [5:0] a, logic [3:0] d, bit junk);
    bit seq_ok = 1'b1, hold_ok = 1'b1;
    logic [3:0] obs = '0, bad = '0, prev = exp_rdata;
    @(negedge clk);
    ce = 1'b1; we = wr; oe = oe_v; addr = a; wd = d;
    for (int k = 1; k <= 8; k++) begin
      @(negedge clk);
      obs = {busy, wl, sense, prech};
      if (obs != exp_seq(k, !wr) || dec_en != wl) begin
        seq_ok = 1'b0; bad = obs;
      end
      if (k <= D && rdata != prev) hold_ok = 1'b0;
      if (junk && k <= D) begin
        ce = 1'($urandom); we = 1'($urandom); oe = 1'($urandom);
        addr = 6'($urandom); wd = 4'($urandom);
      end else ce = 1'b0;
    end
    // R1 R2 R3 R4 R8: strobe sequence per cycle
    check(seq_ok, wr ? "R1/R2/R4/R8 write sequence" : "R1/R2/R3/R4/R8 read sequence",
          {4'h0, bad}, {4'h0, exp_seq(D + 1, !wr)});
    check(hold_ok, "R6 output held during word line", {4'h0, rdata}, {4'h0, prev});
    if (wr) exp_mem[a] = d;
    else begin
      exp_rdata = exp_mem[a];
      exp_drv   = oe_v;
    end
    check(rdata == exp_rdata && drv == exp_drv,
          wr ? "R5 write leaves output" : (oe_v ? "R3 read data" : "R10 read without drive"),
          {3'b0, drv, rdata}, {3'b0, exp_drv, exp_rdata});
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    // R9: reset state
    check({busy, wl, dec_en, sense, prech, drv, rdata} == '0, "R9 reset state",
          {busy, wl, sense, prech, rdata}, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    check({busy, wl, sense, prech, drv, rdata} == '0, "R9 idle after reset",
          {busy, wl, sense, prech, rdata}, 8'h00);

    // R5: initialise every word
    for (int i = 0; i < 64; i++) access(1'b1, 1'b0, 6'(i), 4'(i * 7 + 3), 1'b0);

    // R3: directed reads, incl. boundary addresses
    access(1'b0, 1'b1, 6'd0, 4'h0, 1'b0);
    access(1'b0, 1'b1, 6'd63, 4'h0, 1'b0);
    // R10: read without output enable
    access(1'b0, 1'b0, 6'd5, 4'h0, 1'b0);
    // R5 then R3: write/read same word back to back, junk during busy (R8)
    access(1'b1, 1'b1, 6'd17, 4'hA, 1'b1);
    access(1'b0, 1'b1, 6'd17, 4'h0, 1'b1);

    // R7: idle with ce low and write inputs toggling
    begin
      bit quiet = 1'b1;
      for (int c = 0; c < 12; c++) begin
        @(negedge clk);
        if ({busy, wl, sense, prech} != 4'b0) quiet = 1'b0;
        ce = 1'b0; we = 1'b1; addr = 6'd17; wd = 4'($urandom);
      end
      check(quiet, "R7 no activity with ce low", {4'h0, busy, wl, sense, prech}, 8'h00);
    end
    access(1'b0, 1'b1, 6'd17, 4'h0, 1'b0);  // R7: word unchanged

    // Random mix
    for (int i = 0; i < 300; i++) begin
      int gap = $urandom_range(0, 2);
      repeat (gap) @(negedge clk);
      access(1'($urandom_range(0, 2) == 0), 1'($urandom_range(0, 3) != 0),
             6'($urandom), 4'($urandom), 1'($urandom));
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule